// File: doc/BRIEF.md
# Dual-Mode DMA Transfer Channel

This block is one programmable DMA channel that moves a block of bytes without processor involvement. Software-visible settings (source address, destination address, byte count, operand sizes, address stepping, request source and pacing) are presented on configuration inputs and captured into the channel's own 32-bit address and count registers when a start pulse arrives while the channel is idle. The channel then masters a simple synchronous memory port. A bus cycle completes in any clock where the request and the memory's ready are both high.

Two transfer styles exist. In two-cycle (dual-address) operation, the channel reads from the source and then writes to the destination through an internal holding register. Source and destination operand sizes are chosen independently, so byte streams are packed into words or words are split into bytes. In flyby (single-address) operation, only one address is driven, and an external peripheral supplies or accepts the data in that same bus cycle, qualified by the acknowledge output. Requests come either from an external request line, in burst or cycle-steal form, or from an internal pacer that limits the channel to a chosen share of a 4-cycle window. When the count runs out, the channel goes idle, pulses its done output, sets a sticky status bit and, if enabled, raises an interrupt.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset, busy_o, done_o, stat_done_o, irq_o, mem_req_o and dack_o are all low.
- R2: In two-cycle mode each unit is one or more reads at the source address followed by one or more writes at the destination address. Size code 0 is a byte and 1 is a 16-bit word. A byte travels on data bits [7:0]. A word at address a carries byte a in bits [15:8] and byte a+1 in bits [7:0]. With both addresses stepping, the destination ends up as a byte-exact copy of the source.
- R3: With a byte source and a word destination, two byte reads form one word write, and the first byte read lands in bits [15:8].
- R4: With a word source and a byte destination, one word read yields two byte writes, bits [15:8] first.
- R5: Each address either steps by its own operand size after every bus cycle on it, or stays constant; with a constant destination the last write to it wins.
- R6: The count is in bytes, is 32 bits wide and drops by the destination size per write (by the operand size per flyby cycle). The total number of bus cycles is count/source size + count/destination size. A start with a count of zero completes with no bus cycle. The count is assumed to be a multiple of the larger operand size.
- R7: Flyby mode drives only the source address, sets mem_we_o to the direction input (1 writes memory), uses the source size code, and performs count/size cycles. It waits for the external request even when the internal request source is selected. dack_o is high exactly in cycles where an externally requested bus cycle completes.
- R8: With the external request in burst mode, bus cycles are issued only in clock cycles where dreq_i is high.
- R9: With the external request in cycle-steal mode, each rising edge of dreq_i allows exactly one unit (all reads and writes of one packed/unpacked group, or one flyby cycle), no matter how long dreq_i stays high.
- R10: Internally paced transfers issue bus cycles only in slots 0..bw_sel_i of each 4-cycle window, counted from the first busy cycle. With memory always ready, the allowed slots are filled back to back.
- R11: When the count reaches zero, busy_o falls in the next cycle and done_o pulses for exactly one cycle. stat_done_o stays set until the next accepted start. irq_o equals stat_done_o AND irq_en_i.
- R12: A bus cycle with mem_ready_i low is not taken: address, data and count hold, and the cycle is retried.
- R13: A start pulse while busy is ignored, and the configuration captured at the accepted start stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| src_addr_i | input | 32 | Source (or flyby) start address |
| dst_addr_i | input | 32 | Destination start address |
| count_i | input | 32 | Byte count |
| flyby_i | input | 1 | 1 selects single-address flyby mode |
| fly_wr_i | input | 1 | Flyby direction: 1 writes memory, 0 reads memory |
| ext_req_i | input | 1 | 1 selects the external request, 0 the internal pacer |
| burst_i | input | 1 | External request style: 1 burst, 0 cycle steal |
| bw_sel_i | input | 2 | Internal pacing: slots 0..bw_sel_i of 4 usable |
| src_word_i | input | 1 | Source size code (0 byte, 1 word) |
| dst_word_i | input | 1 | Destination size code (0 byte, 1 word) |
| src_inc_i | input | 1 | Step the source address |
| dst_inc_i | input | 1 | Step the destination address |
| irq_en_i | input | 1 | Interrupt enable |
| dreq_i | input | 1 | External transfer request |
| dack_o | output | 1 | Acknowledge for an externally requested completed bus cycle |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Channel active |
| stat_done_o | output | 1 | Sticky completion status |
| irq_o | output | 1 | Interrupt request |
| mem_req_o | output | 1 | Bus cycle request |
| mem_we_o | output | 1 | Bus cycle is a memory write |
| mem_word_o | output | 1 | Bus cycle size (0 byte, 1 word) |
| mem_addr_o | output | 32 | Bus cycle address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the completing cycle |
| mem_ready_i | input | 1 | Memory completes the cycle |

## Verification
The bench builds the channel with its default widths (32-bit addresses and count, four pacing slots) against a 256-byte memory model. In that model, addresses wrap on their low 8 bits, so whole-memory comparisons catch any stray write. With only two size codes, two stepping flags and four pacing settings, the bench sweeps every two-cycle combination, each both with a memory that is always ready and with one that stalls every third cycle. That sweep reaches all packing and unpacking paths, constant-address overwrite order and the exact slot positions of the pacer. Flyby directions, sizes and stepping are swept separately, and hand-built request waveforms cover burst gaps, cycle-steal edges, a zero count and a start while busy.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FLY} chan_st_e;
endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              ext_i,
  input  logic              burst_i,
  input  logic [SLOT_W-1:0] bw_i,
  input  logic              dreq_i,
  input  logic              unit_done_i,
  output logic              allow_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              dreq_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      dreq_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      dreq_q <= dreq_i;
      if (start_i) slot_q <= '0;
      else if (busy_i) slot_q <= (slot_q == SLOT_W'(SLOTS-1)) ? '0 : slot_q + 1'b1;
      // a fresh edge wins over a unit finishing in the same cycle
      if (start_i) pend_q <= 1'b0;
      else if (dreq_i && !dreq_q) pend_q <= 1'b1;
      else if (unit_done_i) pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (ext_i) allow_o = burst_i ? dreq_i : pend_q;
    else       allow_o = (slot_q <= bw_i);
  end

  // R9
  steal_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done_i && ext_i && !burst_i) |-> pend_q);
  // R10
  slot_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(slot_q));
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack #(
  parameter int DATA_W = 16,
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              src_word_i,
  input  logic              dst_word_i,
  input  logic              sub_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o
);
  logic [DATA_W-1:0] hold_q;
  logic [HALF-1:0]   wbyte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (ld_i) begin
      if (src_word_i)      hold_q <= rdata_i;
      else if (!dst_word_i) hold_q[HALF-1:0] <= rdata_i[HALF-1:0];
      else if (sub_i)      hold_q[HALF-1:0] <= rdata_i[HALF-1:0];
      else                 hold_q[DATA_W-1:HALF] <= rdata_i[HALF-1:0];
    end
  end

  // word split: upper lane goes out first
  assign wbyte   = (src_word_i && !sub_i) ? hold_q[DATA_W-1:HALF] : hold_q[HALF-1:0];
  assign wdata_o = dst_word_i ? hold_q : {{HALF{1'b0}}, wbyte};
endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flyby_i,
  input  logic              fly_wr_i,
  input  logic              ext_req_i,
  input  logic              burst_i,
  input  logic [SLOT_W-1:0] bw_sel_i,
  input  logic              src_word_i,
  input  logic              dst_word_i,
  input  logic              src_inc_i,
  input  logic              dst_inc_i,
  input  logic              irq_en_i,
  input  logic              dreq_i,
  output logic              dack_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              stat_done_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_word_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  chan_st_e          st_q;
  logic              sub_q, done_q, stat_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fly_q, fwr_q, ext_q, burst_q, sw_q, dw_q, si_q, di_q;
  logic [SLOT_W-1:0] bw_q;

  logic busy, cnt_zero, allow, go, xfer, start_acc, two_rd, two_wr, unit_done;
  logic [ADDR_W-1:0] src_step, dst_step;
  logic [CNT_W-1:0]  src_cstep, dst_cstep;

  assign busy      = (st_q != ST_IDLE);
  assign cnt_zero  = (cnt_q == '0);
  assign start_acc = start_i && !busy;
  assign go        = busy && !cnt_zero && allow;
  assign xfer      = go && mem_ready_i;
  assign two_rd    = !sw_q && dw_q;
  assign two_wr    = sw_q && !dw_q;
  assign unit_done = xfer && ((st_q == ST_FLY) || (st_q == ST_WR && !(two_wr && !sub_q)));
  assign src_step  = {{(ADDR_W-2){1'b0}}, sw_q, ~sw_q};
  assign dst_step  = {{(ADDR_W-2){1'b0}}, dw_q, ~dw_q};
  assign src_cstep = {{(CNT_W-2){1'b0}}, sw_q, ~sw_q};
  assign dst_cstep = {{(CNT_W-2){1'b0}}, dw_q, ~dw_q};

  dma_req_gate #(.SLOTS(SLOTS)) u_gate (
    .clk_i, .rst_ni, .start_i(start_acc), .busy_i(busy), .ext_i(ext_q),
    .burst_i(burst_q), .bw_i(bw_q), .dreq_i, .unit_done_i(unit_done), .allow_o(allow)
  );

  dma_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .clk_i, .rst_ni, .ld_i(xfer && st_q == ST_RD), .src_word_i(sw_q),
    .dst_word_i(dw_q), .sub_i(sub_q), .rdata_i(mem_rdata_i), .wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  sub_q <= 1'b0; done_q <= 1'b0; stat_q <= 1'b0;
      src_q <= '0; dst_q <= '0; cnt_q <= '0; bw_q <= '0;
      fly_q <= 1'b0; fwr_q <= 1'b0; ext_q <= 1'b0; burst_q <= 1'b0;
      sw_q <= 1'b0; dw_q <= 1'b0; si_q <= 1'b0; di_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        src_q <= src_addr_i; dst_q <= dst_addr_i; cnt_q <= count_i;
        fly_q <= flyby_i; fwr_q <= fly_wr_i; ext_q <= ext_req_i || flyby_i;
        burst_q <= burst_i; bw_q <= bw_sel_i;
        sw_q <= src_word_i; dw_q <= dst_word_i; si_q <= src_inc_i; di_q <= dst_inc_i;
        st_q <= flyby_i ? ST_FLY : ST_RD;
        sub_q <= 1'b0; stat_q <= 1'b0;
      end else if (busy) begin
        if (cnt_zero) begin
          st_q <= ST_IDLE; done_q <= 1'b1; stat_q <= 1'b1;
        end else if (xfer) begin
          unique case (st_q)
            ST_RD: begin
              if (si_q) src_q <= src_q + src_step;
              if (two_rd && !sub_q) sub_q <= 1'b1;
              else begin sub_q <= 1'b0; st_q <= ST_WR; end
            end
            ST_WR: begin
              if (di_q) dst_q <= dst_q + dst_step;
              cnt_q <= cnt_q - dst_cstep;
              if (two_wr && !sub_q) sub_q <= 1'b1;
              else begin sub_q <= 1'b0; st_q <= ST_RD; end
            end
            ST_FLY: begin
              if (si_q) src_q <= src_q + src_step;
              cnt_q <= cnt_q - src_cstep;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign busy_o      = busy;
  assign done_o      = done_q;
  assign stat_done_o = stat_q;
  assign irq_o       = stat_q && irq_en_i;
  assign mem_req_o   = go;
  assign mem_we_o    = (st_q == ST_WR) || (st_q == ST_FLY && fwr_q);
  assign mem_word_o  = (st_q == ST_WR) ? dw_q : sw_q;
  assign mem_addr_o  = (st_q == ST_WR) ? dst_q : src_q;
  assign dack_o      = xfer && ext_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && stat_done_o));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !dack_o));
  // R6
  cnt_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || cnt_q <= $past(cnt_q)));
  // R12
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> ($stable(mem_addr_o) && $stable(cnt_q) && $stable(mem_we_o)));
  // R5
  fly_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FLY && xfer && !si_q) |=> $stable(src_q));
  // R7
  fly_dack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && fly_q) |-> dack_o);
endmodule

// File: tb/dma_xfer_chan_bench.sv
`timescale 1ns/1ps
module dma_xfer_chan_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, fly = 0, fwr = 0, ext = 0, burst = 0;
  logic sw = 0, dw = 0, si = 1, di = 1, irq_en = 0, dreq = 0, rdy = 1;
  logic [31:0] src_a = 0, dst_a = 0, cnt = 0;
  logic [1:0]  bw = 0;
  logic dack, done, busy, stat, irq, mreq, mwe, mword;
  logic [31:0] maddr;
  logic [15:0] mwdata, mrdata;

  logic [7:0] mem [256];
  logic [7:0] init_m [256];
  logic [7:0] exp_m [256];

  int total = 0, bad = 0, rp = 0;
  int nbus, bidx, ndone, last_bidx, done_bidx;
  int slot_bad, burst_bad, dack_bad, fly_bad;
  logic [31:0] fly_exp;

  always #2 clk = ~clk;

  dma_xfer_chan u_dma_xfer_chan (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_addr_i(src_a), .dst_addr_i(dst_a),
    .count_i(cnt), .flyby_i(fly), .fly_wr_i(fwr), .ext_req_i(ext), .burst_i(burst),
    .bw_sel_i(bw), .src_word_i(sw), .dst_word_i(dw), .src_inc_i(si), .dst_inc_i(di),
    .irq_en_i(irq_en), .dreq_i(dreq), .dack_o(dack), .done_o(done), .busy_o(busy),
    .stat_done_o(stat), .irq_o(irq), .mem_req_o(mreq), .mem_we_o(mwe), .mem_word_o(mword),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_ready_i(rdy)
  );

  assign mrdata = mword ? {mem[maddr[7:0]], mem[8'(maddr[7:0] + 8'd1)]} : {8'h00, mem[maddr[7:0]]};

  int gcyc = 0;
  always @(negedge clk) begin
    gcyc++;
    rdy = (rp != 0) ? ((gcyc % 3) != 1) : 1'b1;
    #1;
    if (busy) bidx++;
    if (mreq && rdy) begin
      nbus++;
      last_bidx = bidx;
      if (!(ext || fly) && ((bidx % 4) > int'(bw))) slot_bad++;
      if ((ext || fly) && burst && !dreq) burst_bad++;
      if (dack != (ext || fly)) dack_bad++;
      if (fly) begin
        if (maddr != fly_exp || mwe != fwr || mword != sw) fly_bad++;
        if (si) fly_exp = fly_exp + (sw ? 32'd2 : 32'd1);
      end else if (mwe) begin
        if (mword) begin
          mem[maddr[7:0]] = mwdata[15:8];
          mem[8'(maddr[7:0] + 8'd1)] = mwdata[7:0];
        end else mem[maddr[7:0]] = mwdata[7:0];
      end
    end
    if (done) begin ndone++; done_bidx = bidx; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic reset_mem();
    for (int i = 0; i < 256; i++) begin
      init_m[i] = 8'(i * 37 + 11);
      mem[i] = init_m[i];
    end
  endtask

  task automatic build_exp(input int s, input int d, input int c, input bit ws, input bit wd,
                           input bit is, input bit id);
    int sb, db;
    sb = ws ? 2 : 1;
    db = wd ? 2 : 1;
    for (int i = 0; i < 256; i++) exp_m[i] = init_m[i];
    for (int k = 0; k < c; k++)
      exp_m[(d + (id ? k : k % db)) & 255] = init_m[(s + (is ? k : k % sb)) & 255];
  endtask

  task automatic cmp_mem(input string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic start_xfer(input int s, input int d, input int c, input bit ws, input bit wd,
                            input bit is, input bit id, input int b, input bit e, input bit bu,
                            input bit f, input bit fw);
    @(negedge clk);
    src_a = 32'(s); dst_a = 32'(d); cnt = 32'(c);
    sw = ws; dw = wd; si = is; di = id; bw = 2'(b);
    ext = e; burst = bu; fly = f; fwr = fw;
    nbus = 0; bidx = -1; ndone = 0; last_bidx = -1; done_bidx = -9;
    slot_bad = 0; burst_bad = 0; dack_bad = 0; fly_bad = 0;
    fly_exp = 32'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    int n = 0;
    while (ndone == 0 && n < lim) begin @(posedge clk); n++; end
    chk(ndone == 1, "R11 completion seen", ndone, 1);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    reset_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, stat, irq, mreq, dack} == 6'b0, "R1", int'({busy, done, stat, irq, mreq, dack}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // two-cycle internal sweep
    for (int p = 0; p < 2; p++)
      for (int ss = 0; ss < 2; ss++)
        for (int ds = 0; ds < 2; ds++)
          for (int isi = 0; isi < 2; isi++)
            for (int idi = 0; idi < 2; idi++)
              for (int b = 0; b < 4; b++) begin
                string tag;
                int sb, db, nb, nn;
                rp = p;
                reset_mem();
                start_xfer(16, 128, 8, ss[0], ds[0], isi[0], idi[0], b, 0, 0, 0, 0);
                wait_done(2000);
                rp = 0;
                sb = ss ? 2 : 1; db = ds ? 2 : 1;
                nb = 8 / sb + 8 / db; nn = b + 1;
                build_exp(16, 128, 8, ss[0], ds[0], isi[0], idi[0]);
                if (!isi || !idi) tag = "R5";
                else if (ss == 0 && ds == 1) tag = "R3";
                else if (ss == 1 && ds == 0) tag = "R4";
                else tag = "R2";
                if (p != 0) tag = {tag, " R12"};
                cmp_mem(tag);
                chk(nbus == nb, "R6 bus cycles", nbus, nb);
                chk(slot_bad == 0 && dack_bad == 0, "R10 slot use", slot_bad + dack_bad, 0);
                if (p == 0) begin
                  chk(last_bidx == ((nb - 1) / nn) * 4 + (nb - 1) % nn, "R10 last slot",
                      last_bidx, ((nb - 1) / nn) * 4 + (nb - 1) % nn);
                  chk(done_bidx == last_bidx + 1, "R11 done timing", done_bidx, last_bidx + 1);
                end
              end

    // zero count
    reset_mem();
    start_xfer(16, 128, 0, 1, 1, 1, 1, 3, 0, 0, 0, 0);
    wait_done(50);
    chk(nbus == 0 && done_bidx == 0, "R6 zero count", nbus * 10 + done_bidx, 0);

    // start while busy, then interrupt behaviour
    reset_mem();
    irq_en = 1'b1;
    start_xfer(16, 128, 8, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    dst_a = 32'd192; cnt = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dst_a = 32'd128; cnt = 32'd8;
    wait_done(500);
    build_exp(16, 128, 8, 1, 1, 1, 1);
    cmp_mem("R13");
    chk(nbus == 8, "R13 bus cycles", nbus, 8);
    @(negedge clk);
    chk(irq == 1'b1 && stat == 1'b1, "R11 irq set", int'({irq, stat}), 3);
    irq_en = 1'b0;
    #1;
    chk(irq == 1'b0 && stat == 1'b1, "R11 irq masked", int'({irq, stat}), 1);
    start_xfer(16, 128, 2, 1, 1, 1, 1, 3, 0, 0, 0, 0);
    chk(stat == 1'b0, "R11 status cleared by start", int'(stat), 0);
    wait_done(100);

    // flyby sweep in burst style
    for (int fw = 0; fw < 2; fw++)
      for (int fz = 0; fz < 2; fz++)
        for (int fi = 0; fi < 2; fi++) begin
          reset_mem();
          dreq = 1'b0;
          start_xfer(40, 200, 4, fz[0], 1'b0, fi[0], 1'b1, 3, 0, 1, 1, fw[0]);
          repeat (6) @(negedge clk);
          chk(nbus == 0, "R7 waits for request", nbus, 0);
          dreq = 1'b1;
          wait_done(200);
          @(negedge clk);
          dreq = 1'b0;
          chk(nbus == 4 / (fz ? 2 : 1), "R7 flyby cycles", nbus, 4 / (fz ? 2 : 1));
          chk(fly_bad == 0 && dack_bad == 0, "R7 flyby address/dack", fly_bad + dack_bad, 0);
          build_exp(0, 0, 0, 0, 0, 1, 1);
          cmp_mem("R7 no data through channel");
        end

    // burst two-cycle with gaps
    begin
      int g = 0;
      reset_mem();
      dreq = 1'b0;
      start_xfer(16, 128, 16, 1, 1, 1, 1, 0, 1, 1, 0, 0);
      while (ndone == 0 && g < 400) begin
        @(negedge clk);
        dreq = (g % 5) < 3;
        g++;
      end
      dreq = 1'b0;
      chk(burst_bad == 0, "R8 cycles only with request", burst_bad, 0);
      chk(nbus == 16, "R8 bus cycles", nbus, 16);
      chk(dack_bad == 0, "R7 dack in external mode", dack_bad, 0);
      build_exp(16, 128, 16, 1, 1, 1, 1);
      cmp_mem("R8");
    end

    // cycle steal, two-cycle packing
    reset_mem();
    dreq = 1'b0;
    start_xfer(16, 128, 4, 0, 1, 1, 1, 0, 1, 0, 0, 0);
    repeat (2) @(negedge clk);
    dreq = 1'b1;
    repeat (8) @(negedge clk);
    chk(nbus == 3, "R9 one unit per edge", nbus, 3);
    dreq = 1'b0;
    repeat (3) @(negedge clk);
    chk(nbus == 3, "R9 no edge no unit", nbus, 3);
    dreq = 1'b1;
    wait_done(100);
    dreq = 1'b0;
    chk(nbus == 6, "R9 second unit", nbus, 6);
    build_exp(16, 128, 4, 0, 1, 1, 1);
    cmp_mem("R9");

    // cycle steal, flyby
    reset_mem();
    start_xfer(60, 0, 6, 1, 0, 1, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); dreq = 1'b1;
      @(negedge clk);
      @(negedge clk); dreq = 1'b0;
      repeat (3) @(negedge clk);
      chk(nbus == k + 1, "R9 flyby per edge", nbus, k + 1);
    end
    wait_done(50);
    chk(fly_bad == 0, "R7 flyby steal addresses", fly_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule